// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block is the address glue for an 8-bit processor with a 16-bit address bus. It divides the 64 KiB processor space into four 16 KiB slots. Each slot is steered through its own 8-bit mapping register to one 16 KiB page of a 512 KiB RAM or of a 32 KiB ROM. The block drives the RAM and ROM chip selects, the RAM write enable and the extended high address lines that sit above processor address bit 13.

A fixed 128-byte IO window is carved out of slot 0. It is split into eight 16-byte sections, and each section has its own select line. Section 0 holds the mapping registers themselves. The processor writes them on a rising clock edge and can read them back through the block's data output. The IO window is decoded before the slot mapping, so it stays reachable whatever page slot 0 holds.

Top module: `bank_decoder`

## Requirements
- R1: An address in $0200–$027F is an IO access. `io_sel_o` bit k is asserted, with k = address bits [6:4]; every other select bit, `ram_cs_o`, `rom_cs_o` and `mem_we_o` are low, and `hi_addr_o` is 0. The section order is: 0 mapping registers, 1 VIA, 2 UART, 3 video, 4 sound, 5 expansion 0, 6 expansion 1, 7 reserved.
- R2: Outside the IO window, address bits [15:14] choose the slot, and the mapping register with the same index controls the access.
- R3: When the selected register has bit 7 = 0, `ram_cs_o` is high, `rom_cs_o` is low, and `hi_addr_o` equals register bits [4:0].
- R4: When the selected register has bit 7 = 1, `rom_cs_o` is high, `ram_cs_o` is low, and `hi_addr_o` is {4'b0, register bit 0}.
- R5: While reset is asserted, registers 0, 1, 2 and 3 hold $00, $01, $02 and $81 respectively.
- R6: An access to section 0 with `rnw_i` = 0 stores all 8 bits of `data_i` into register address bits [1:0] at the rising clock edge.
- R7: An access to section 0 with `rnw_i` = 1 drives `data_o` with register address bits [1:0], including the reserved bits 5–6 as they were written, and raises `data_oe_o`. At any other time `data_oe_o` is 0 and `data_o` is $00.
- R8: `mem_we_o` is high only for a RAM access with `rnw_i` = 0. A write to a slot mapped to ROM asserts no write enable.
- R9: The IO window is decoded the same way whatever value register 0 holds, including a ROM mapping.
- R10: Writes to IO sections 1–7 and writes to memory leave all four mapping registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor bus clock; mapping registers are written on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Processor address |
| data_i | input | 8 | Processor write data |
| rnw_i | input | 1 | 1 = read, 0 = write |
| data_o | output | 8 | Mapping register read-back data |
| data_oe_o | output | 1 | High while `data_o` carries read-back data |
| ram_cs_o | output | 1 | RAM chip select |
| rom_cs_o | output | 1 | ROM chip select |
| mem_we_o | output | 1 | RAM write enable |
| hi_addr_o | output | 5 | Physical address bits [18:14] |
| io_sel_o | output | 8 | One-hot IO section select |

## Verification
Two cases are hard to reach from the ports. The first is the IO window override: it only matters after slot 0 has been remapped away from its reset page, and a ROM mapping is the most telling choice. The bench therefore writes $81 into register 0 and then probes the window edges at $0200, $027F and $0280, as well as a plain slot 0 address. The second is a register that was left unchanged. That can only be observed by reading it back through section 0 after a write aimed at another section or at a ROM slot. A long random phase follows. It biases addresses toward the register section and the window boundaries, so that mappings change often while memory accesses continue.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned SLOT_N   = 4;
  localparam int unsigned PAGE_W   = 5;
  localparam int unsigned SECT_N   = 8;
  localparam int unsigned SECT_B   = 16;
  localparam int unsigned ROM_BIT  = 7;
  localparam logic [ADDR_W-1:0] IO_BASE = 16'h0200;
  localparam int unsigned SLOT_W   = $clog2(SLOT_N);

  typedef logic [DATA_W-1:0] map_t;
endpackage

// File: rtl/bank_map_regs.sv
module bank_map_regs
  import bank_pkg::*;
#(
  parameter int unsigned ROM_BOOT_PAGE = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [SLOT_W-1:0]        idx_i,
  input  map_t                     wdata_i,
  output logic [SLOT_N-1:0][DATA_W-1:0] regs_o
);
  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    localparam map_t RST_VAL = (s == SLOT_N-1)
      ? map_t'((1 << ROM_BIT) | ROM_BOOT_PAGE)
      : map_t'(s);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_o[s] <= RST_VAL;
      else if (wr_en_i && idx_i == SLOT_W'(s))       regs_o[s] <= wdata_i;
    end
  end

  // R6
  reg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> regs_o[$past(idx_i)] == $past(wdata_i));
endmodule

// File: rtl/bank_io_decode.sv
module bank_io_decode
  import bank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic              io_hit_o,
  output logic [SECT_N-1:0] sel_o
);
  localparam int unsigned OFF_W = $clog2(SECT_B);
  localparam int unsigned SEC_W = $clog2(SECT_N);
  localparam int unsigned WIN_W = OFF_W + SEC_W;

  logic [SEC_W-1:0] sect;
  assign io_hit_o = addr_i[ADDR_W-1:WIN_W] == IO_BASE[ADDR_W-1:WIN_W];
  assign sect     = addr_i[WIN_W-1:OFF_W];

  for (genvar k = 0; k < SECT_N; k++) begin : g_sel
    assign sel_o[k] = io_hit_o && (sect == SEC_W'(k));
  end

  // R1
  io_onehot_chk: assert property (@(addr_i) $onehot0(sel_o) && (io_hit_o == |sel_o));
endmodule

// File: rtl/bank_slot_map.sv
module bank_slot_map
  import bank_pkg::*;
(
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          io_hit_i,
  input  logic                          rnw_i,
  input  logic [SLOT_N-1:0][DATA_W-1:0] regs_i,
  output logic                          ram_cs_o,
  output logic                          rom_cs_o,
  output logic                          mem_we_o,
  output logic [PAGE_W-1:0]             hi_addr_o
);
  logic [SLOT_W-1:0] slot;
  map_t              cur;
  logic              is_rom;

  assign slot   = addr_i[ADDR_W-1 -: SLOT_W];
  assign cur    = regs_i[slot];
  assign is_rom = cur[ROM_BIT];

  always_comb begin
    ram_cs_o  = !io_hit_i && !is_rom;
    rom_cs_o  = !io_hit_i &&  is_rom;
    mem_we_o  = ram_cs_o && !rnw_i;
    hi_addr_o = '0;
    if (ram_cs_o)      hi_addr_o = cur[PAGE_W-1:0];
    else if (rom_cs_o) hi_addr_o = PAGE_W'(cur[0]);
  end
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic [7:0]        data_i,
  input  logic              rnw_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic              ram_cs_o,
  output logic              rom_cs_o,
  output logic              mem_we_o,
  output logic [4:0]        hi_addr_o,
  output logic [7:0]        io_sel_o
);
  localparam int unsigned REG_SECT = 0;

  logic                          io_hit;
  logic                          reg_sel;
  logic [SLOT_W-1:0]             reg_idx;
  logic [SLOT_N-1:0][DATA_W-1:0] regs;

  bank_io_decode u_io (
    .addr_i   (addr_i),
    .io_hit_o (io_hit),
    .sel_o    (io_sel_o)
  );

  assign reg_sel = io_sel_o[REG_SECT];
  assign reg_idx = addr_i[SLOT_W-1:0];

  bank_map_regs #(.ROM_BOOT_PAGE(1)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (reg_sel && !rnw_i),
    .idx_i   (reg_idx),
    .wdata_i (data_i),
    .regs_o  (regs)
  );

  bank_slot_map u_map (
    .addr_i    (addr_i),
    .io_hit_i  (io_hit),
    .rnw_i     (rnw_i),
    .regs_i    (regs),
    .ram_cs_o  (ram_cs_o),
    .rom_cs_o  (rom_cs_o),
    .mem_we_o  (mem_we_o),
    .hi_addr_o (hi_addr_o)
  );

  assign data_oe_o = reg_sel && rnw_i;
  assign data_o    = data_oe_o ? regs[reg_idx] : '0;

  // R3 R4
  cs_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_cs_o && rom_cs_o) && !((ram_cs_o || rom_cs_o) && (io_sel_o != '0)));
  // R8
  rom_no_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_cs_o || !rnw_i && io_sel_o != '0) |-> !mem_we_o);
  // R9
  io_override_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:7] == 9'h004) |-> (io_sel_o != '0) && !ram_cs_o && !rom_cs_o);
  // R10
  reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_sel_o[REG_SECT] && !rnw_i) |=> $stable(regs));
endmodule

// File: tb/test_bank_decoder.sv
module test_bank_decoder;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] addr = 0;
  logic [7:0]  wdata = 0;
  logic        rnw = 1;
  logic [7:0]  data_o;
  logic        data_oe, ram_cs, rom_cs, mem_we;
  logic [4:0]  hi_addr;
  logic [7:0]  io_sel;

  int n_cmp = 0, n_bad = 0;
  int model [4];
  bit done = 0;

  always #5 clk = ~clk;

  bank_decoder i_bank_decoder (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(wdata), .rnw_i(rnw),
    .data_o(data_o), .data_oe_o(data_oe), .ram_cs_o(ram_cs), .rom_cs_o(rom_cs),
    .mem_we_o(mem_we), .hi_addr_o(hi_addr), .io_sel_o(io_sel)
  );

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s addr=%h rnw=%0d actual=%h expected=%h", req, addr, rnw, act, exp);
    end
  endtask

  // Behavioural reference: compare every output for the current bus state
  task automatic compare_all();
    int e_sel = 0, e_ram = 0, e_rom = 0, e_we = 0, e_hi = 0, e_d = 0, e_oe = 0;
    bit in_io = (addr >= 16'h0200) && (addr <= 16'h027F);
    if (in_io) begin
      int sec = (addr - 16'h0200) / 16;
      e_sel = 1 << sec;                              // R1
      if (sec == 0 && rnw) begin                     // R7
        e_oe = 1;
        e_d = model[addr % 4];
      end
    end else begin
      int m = model[addr / 16384];                   // R2
      if (m >= 128) begin e_rom = 1; e_hi = m % 2; end        // R4
      else begin e_ram = 1; e_hi = m % 32; e_we = !rnw; end  // R3 R8
    end
    check("R1_io_sel", io_sel, e_sel);
    check("R3_ram_cs", ram_cs, e_ram);
    check("R4_rom_cs", rom_cs, e_rom);
    check("R2_hi_addr", hi_addr, e_hi);
    check("R8_mem_we", mem_we, e_we);
    check("R7_data_oe", data_oe, e_oe);
    check("R7_data_o", data_o, e_d);
  endtask

  task automatic cycle(logic [15:0] a, logic r, logic [7:0] d);
    @(negedge clk);
    addr = a; rnw = r; wdata = d;
    #4;
    compare_all();
    @(posedge clk);
    // R6: model register write
    if (rst_n && !r && a >= 16'h0200 && a <= 16'h020F) model[a % 4] = d;
  endtask

  initial begin
    model[0] = 8'h00; model[1] = 8'h01; model[2] = 8'h02; model[3] = 8'h81;
    // R5: read-back under reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); addr = 16'h0200 + 16'(i); rnw = 1; #4;
      check("R5_reset_val", data_o, model[i]);
    end
    @(negedge clk); rst_n = 1;
    // R2 R3 R4: each slot under reset mapping
    cycle(16'h0000, 1, 0); cycle(16'h4123, 1, 0); cycle(16'hBFFF, 1, 0); cycle(16'hFFFC, 1, 0);
    // R1: window edges and every section
    for (int s = 0; s < 8; s++) cycle(16'h0200 + 16'(s*16) + 16'(s), 1, 0);
    cycle(16'h01FF, 1, 0); cycle(16'h027F, 1, 0); cycle(16'h0280, 1, 0);
    // R9: slot 0 mapped to ROM, IO window still decoded
    cycle(16'h0200, 0, 8'h81);
    cycle(16'h0200, 1, 0); cycle(16'h0210, 1, 0); cycle(16'h027F, 0, 8'h55);
    cycle(16'h0100, 1, 0); cycle(16'h0280, 0, 8'h11);
    // R8: write to ROM slot, write to RAM slot
    cycle(16'hC000, 0, 8'hAA); cycle(16'h8000, 0, 8'hAA);
    // R7: reserved bits read back as written
    cycle(16'h0201, 0, 8'h7F); cycle(16'h0201, 1, 0); cycle(16'h4000, 0, 8'h00);
    // R10: writes elsewhere leave registers intact
    cycle(16'h0222, 0, 8'hFF); cycle(16'h0253, 0, 8'hFF); cycle(16'h2000, 0, 8'hFF);
    for (int i = 0; i < 4; i++) cycle(16'h0200 + 16'(i), 1, 0);
    // R6 aliasing within register section
    cycle(16'h020E, 0, 8'h9E); cycle(16'h0202, 1, 0); cycle(16'h8888, 1, 0);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      int sel = $urandom_range(0, 9);
      logic [15:0] a;
      logic [7:0]  d = 8'($urandom);
      if (sel < 3)      a = 16'h0200 + 16'($urandom_range(0, 15));
      else if (sel < 5) a = 16'h01F8 + 16'($urandom_range(0, 15)) + 16'(($urandom_range(0,1)) * 16'h80);
      else              a = 16'($urandom);
      cycle(a, 1'($urandom), d);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule